// File: doc/BRIEF.md
# Windowed Integer Register File

This block stores the integer operands of a processor core that uses overlapping register windows. Instructions name one of 32 architectural registers. Name 0 is a constant zero. Names 1 through 7 reach seven shared global registers. Names 8 through 31 are translated through the current window pointer into a ring of 16 × 8 = 128 physical 64-bit registers. Consecutive windows overlap, so a caller's outgoing registers become the callee's incoming registers without any copying.

Two read ports are combinational. Port B can also fetch the second half of a register pair, which is register n+1 after port A's n, each name translated on its own. A single write port stores on the rising clock edge. A mode pin selects 64-bit or 32-bit access. In 32-bit mode, writes are sign-extended and reads return only the low word. A read that names the physical register being written in the same cycle returns the incoming value.

The block also holds the window pointer and four window-bookkeeping counters. They change only through a dedicated state-update port that carries a select field.

The write port is a valid/ready stream. `wr_ready` is high in every cycle, so the block never applies back-pressure. A write is accepted in every cycle where `wr_valid` and `wr_ready` are both high. No data is held back across cycles. Control pins and the read ports are plain signals.

Top module: `winreg_file`

## Requirements
- R1: On reset, `win_ptr`, `restore_avail` and `foreign_wins` read 0, `save_avail` reads 6 (windows minus two), `clean_wins` reads 7 (windows minus one), and every register reads zero.
- R2: Register name 0 always reads zero on both ports, and a write to it changes nothing.
- R3: Names 1 to 7 select global registers 0 to 6, whatever the window pointer.
- R4: Names 8 to 31 select physical entry 16·w + (n mod 16), where w = (P − ⌊n/16⌋ + 8) mod 8 and P is `win_ptr`.
- R5: Name n in 24..31 under pointer P reaches the same storage as name n−16 under pointer (P−1) mod 8.
- R6: An accepted write is visible on both read ports from the next cycle on. In the write cycle, a read of the same physical register returns the new value.
- R7: With `w32`=1, a write stores bits 31:0 sign-extended to 64 bits, and reads return bits 31:0 of the stored value with bits 63:32 zero. With `w32`=0, all 64 bits pass unchanged.
- R8: With `rb_pair`=1, port B ignores `rb_num` and reads name (`ra_num`+1) mod 32, translated independently of port A.
- R9: When `st_we` is high, `st_sel` picks the state register loaded from `st_data` on the next edge: 0 `win_ptr`, 1 `save_avail`, 2 `restore_avail`, 3 `foreign_wins`, 4 `clean_wins`. Codes 5 to 7 change nothing, and with `st_we` low every state register holds.
- R10: `wr_ready` is always high. A cycle with `wr_valid` low changes no register.
- R11: A window pointer of 8 or more selects the same storage as its value mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| w32 | input | 1 | 1 = 32-bit access, 0 = 64-bit access |
| ra_num | input | 5 | Port A register name |
| ra_data | output | 64 | Port A read data |
| rb_num | input | 5 | Port B register name (used when `rb_pair`=0) |
| rb_pair | input | 1 | Port B reads `ra_num`+1 |
| rb_data | output | 64 | Port B read data |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_num | input | 5 | Write register name |
| wr_data | input | 64 | Write data |
| st_we | input | 1 | State-register update enable |
| st_sel | input | 3 | State register select |
| st_data | input | 5 | State register new value |
| win_ptr | output | 5 | Current window pointer |
| save_avail | output | 5 | Windows available to save |
| restore_avail | output | 5 | Windows available to restore |
| foreign_wins | output | 5 | Windows owned by another context |
| clean_wins | output | 5 | Clean windows |

## Verification
The assertions check the following on every cycle:
- a name of zero reads zero;
- the same-cycle write bypass on port A;
- the zeroed upper word in 32-bit mode;
- the wrap of a pair read at name 31 to zero;
- the state-update port's load-and-hold behaviour.

The bench checks the other behaviours against an arithmetic model of the mapping:
- the window translation itself;
- the overlap between neighbouring windows;
- global independence from the pointer;
- sign extension on 32-bit writes;
- pointer values above 7.

The model is swept over every pointer value and every register name, because a wrong index shows up only after data has been written under one pointer and read under another.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int NAME_W  = 5;
  localparam int STATE_W = 5;
  localparam int GLOB_N  = 7;
  localparam int GIDX_W  = 3;
  localparam int WIN_REGS = 16;

  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_GLOB = 2'd1,
    K_WIN  = 2'd2
  } rkind_e;

  typedef enum logic [2:0] {
    SEL_PTR     = 3'd0,
    SEL_SAVE    = 3'd1,
    SEL_RESTORE = 3'd2,
    SEL_FOREIGN = 3'd3,
    SEL_CLEAN   = 3'd4
  } stsel_e;
endpackage

// File: rtl/winreg_map.sv
// Translates an architectural name into a storage class and index (R2, R3, R4, R11).
module winreg_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int WINW   = $clog2(NWIN),
  localparam int WIDX_W = WINW + 4
) (
  input  logic [NAME_W-1:0]  name,
  input  logic [STATE_W-1:0] ptr,
  output rkind_e             kind,
  output logic [GIDX_W-1:0]  gidx,
  output logic [WIDX_W-1:0]  widx
);
  localparam int SUM_W = STATE_W + 2;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wmod;
  logic [WINW-1:0]  win;

  always_comb begin
    // window = (ptr - name/16 + NWIN) mod NWIN
    sum  = SUM_W'(ptr) + SUM_W'(NWIN) - SUM_W'(name[NAME_W-1]);
    wmod = sum % SUM_W'(NWIN);
    win  = wmod[WINW-1:0];
    widx = {win, name[3:0]};
    gidx = name[GIDX_W-1:0] - GIDX_W'(1);
    if (name == '0)                  kind = K_ZERO;
    else if (name < NAME_W'(GLOB_N + 1)) kind = K_GLOB;
    else                             kind = K_WIN;
  end
endmodule

// File: rtl/winreg_state.sv
// Window pointer and bookkeeping counters behind a select-field update port (R1, R9).
module winreg_state
  import winreg_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] ptr,
  output logic [STATE_W-1:0] save_avail,
  output logic [STATE_W-1:0] restore_avail,
  output logic [STATE_W-1:0] foreign_wins,
  output logic [STATE_W-1:0] clean_wins
);
  localparam logic [STATE_W-1:0] SAVE_RST  = STATE_W'(NWIN - 2);
  localparam logic [STATE_W-1:0] CLEAN_RST = STATE_W'(NWIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr           <= '0;
      save_avail    <= SAVE_RST;
      restore_avail <= '0;
      foreign_wins  <= '0;
      clean_wins    <= CLEAN_RST;
    end else if (we) begin
      case (sel)
        SEL_PTR:     ptr           <= din;
        SEL_SAVE:    save_avail    <= din;
        SEL_RESTORE: restore_avail <= din;
        SEL_FOREIGN: foreign_wins  <= din;
        SEL_CLEAN:   clean_wins    <= din;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/winreg_bank.sv
// Global and windowed storage with write-first read bypass (R6).
module winreg_bank
  import winreg_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  parameter int NRD  = 2,
  localparam int NPHYS  = WIN_REGS * NWIN,
  localparam int WIDX_W = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  rkind_e            wkind,
  input  logic [GIDX_W-1:0] wgidx,
  input  logic [WIDX_W-1:0] wwidx,
  input  logic [XLEN-1:0]   wdata,
  input  rkind_e            rkind [NRD],
  input  logic [GIDX_W-1:0] rgidx [NRD],
  input  logic [WIDX_W-1:0] rwidx [NRD],
  output logic [XLEN-1:0]   rdata [NRD]
);
  logic [XLEN-1:0] gq [GLOB_N];
  logic [XLEN-1:0] wq [NPHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GLOB_N; i++) gq[i] <= '0;
      for (int i = 0; i < NPHYS; i++)  wq[i] <= '0;
    end else if (we) begin
      case (wkind)
        K_GLOB:  gq[wgidx] <= wdata;
        K_WIN:   wq[wwidx] <= wdata;
        default: ;   // name 0: discarded (R2)
      endcase
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XLEN-1:0] stored;
    logic            hit;
    always_comb begin
      case (rkind[p])
        K_GLOB:  stored = gq[rgidx[p]];
        K_WIN:   stored = wq[rwidx[p]];
        default: stored = '0;
      endcase
      hit = we && (rkind[p] == wkind) && (rkind[p] != K_ZERO) &&
            ((rkind[p] == K_GLOB) ? (rgidx[p] == wgidx) : (rwidx[p] == wwidx));
      rdata[p] = hit ? wdata : stored;
    end
  end
endmodule

// File: rtl/winreg_file.sv
// Top: name translation, width formatting, pair addressing, storage and state.
module winreg_file
  import winreg_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               w32,
  input  logic [NAME_W-1:0]  ra_num,
  output logic [XLEN-1:0]    ra_data,
  input  logic [NAME_W-1:0]  rb_num,
  input  logic               rb_pair,
  output logic [XLEN-1:0]    rb_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [NAME_W-1:0]  wr_num,
  input  logic [XLEN-1:0]    wr_data,
  input  logic               st_we,
  input  logic [2:0]         st_sel,
  input  logic [STATE_W-1:0] st_data,
  output logic [STATE_W-1:0] win_ptr,
  output logic [STATE_W-1:0] save_avail,
  output logic [STATE_W-1:0] restore_avail,
  output logic [STATE_W-1:0] foreign_wins,
  output logic [STATE_W-1:0] clean_wins
);
  localparam int NRD    = 2;
  localparam int WIDX_W = $clog2(WIN_REGS * NWIN);
  localparam int HI_W   = XLEN - 32;

  // Write side: always ready, sign-extend in 32-bit mode (R7, R10)
  logic              wr_fire;
  logic [XLEN-1:0]   wr_fmt;
  rkind_e            wkind;
  logic [GIDX_W-1:0] wgidx;
  logic [WIDX_W-1:0] wwidx;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_fmt   = w32 ? {{HI_W{wr_data[31]}}, wr_data[31:0]} : wr_data;

  winreg_map #(.NWIN(NWIN)) u_wmap (
    .name (wr_num),
    .ptr  (win_ptr),
    .kind (wkind),
    .gidx (wgidx),
    .widx (wwidx)
  );

  // Read side: port B can fetch the pair partner of port A (R8)
  logic [NAME_W-1:0] rname [NRD];
  rkind_e            rkind [NRD];
  logic [GIDX_W-1:0] rgidx [NRD];
  logic [WIDX_W-1:0] rwidx [NRD];
  logic [XLEN-1:0]   rraw  [NRD];
  logic [XLEN-1:0]   rfmt  [NRD];

  assign rname[0] = ra_num;
  assign rname[1] = rb_pair ? (ra_num + NAME_W'(1)) : rb_num;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    winreg_map #(.NWIN(NWIN)) u_rmap (
      .name (rname[p]),
      .ptr  (win_ptr),
      .kind (rkind[p]),
      .gidx (rgidx[p]),
      .widx (rwidx[p])
    );
    assign rfmt[p] = w32 ? {{HI_W{1'b0}}, rraw[p][31:0]} : rraw[p];
  end

  assign ra_data = rfmt[0];
  assign rb_data = rfmt[1];

  winreg_bank #(.XLEN(XLEN), .NWIN(NWIN), .NRD(NRD)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .wkind (wkind),
    .wgidx (wgidx),
    .wwidx (wwidx),
    .wdata (wr_fmt),
    .rkind (rkind),
    .rgidx (rgidx),
    .rwidx (rwidx),
    .rdata (rraw)
  );

  winreg_state #(.NWIN(NWIN)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .we            (st_we),
    .sel           (st_sel),
    .din           (st_data),
    .ptr           (win_ptr),
    .save_avail    (save_avail),
    .restore_avail (restore_avail),
    .foreign_wins  (foreign_wins),
    .clean_wins    (clean_wins)
  );
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            w32,
  input logic [4:0]      ra_num,
  input logic [XLEN-1:0] ra_data,
  input logic            rb_pair,
  input logic [XLEN-1:0] rb_data,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [4:0]      wr_num,
  input logic [XLEN-1:0] wr_data,
  input logic            st_we,
  input logic [2:0]      st_sel,
  input logic [4:0]      st_data,
  input logic [4:0]      win_ptr,
  input logic [4:0]      save_avail,
  input logic [4:0]      restore_avail,
  input logic [4:0]      foreign_wins,
  input logic [4:0]      clean_wins
);
  localparam int HI_W = XLEN - 32;

  p_zero_name_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_num == 5'd0) |-> (ra_data == '0))
    else $error("name 0 read nonzero");

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_num != 5'd0 && ra_num == wr_num) |->
      (ra_data == (w32 ? {{HI_W{1'b0}}, wr_data[31:0]} : wr_data)))
    else $error("write-first bypass broken");

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w32 |-> (ra_data[XLEN-1:32] == '0 && rb_data[XLEN-1:32] == '0))
    else $error("32-bit read upper word nonzero");

  p_pair_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_pair && ra_num == 5'd31) |-> (rb_data == '0))
    else $error("pair of name 31 did not wrap to zero");

  p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_sel == 3'd0) |=> (win_ptr == $past(st_data)))
    else $error("window pointer not loaded");

  p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> $stable({win_ptr, save_avail, restore_avail, foreign_wins, clean_wins}))
    else $error("state changed without update");
endmodule

bind winreg_file winreg_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_winreg_file.sv
module test_winreg_file;
  localparam int XLEN = 64;
  localparam int NWIN = 8;
  localparam int NPHYS = 16 * NWIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w32 = 1'b0;
  logic [4:0] ra_num = '0, rb_num = '0, wr_num = '0;
  logic rb_pair = 1'b0, wr_valid = 1'b0, st_we = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic [2:0] st_sel = '0;
  logic [4:0] st_data = '0;
  logic [XLEN-1:0] ra_data, rb_data;
  logic wr_ready;
  logic [4:0] win_ptr, save_avail, restore_avail, foreign_wins, clean_wins;

  always #5 clk = ~clk;

  winreg_file #(.XLEN(XLEN), .NWIN(NWIN)) i_winreg_file (
    .clk(clk), .rst_n(rst_n), .w32(w32),
    .ra_num(ra_num), .ra_data(ra_data),
    .rb_num(rb_num), .rb_pair(rb_pair), .rb_data(rb_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_num(wr_num), .wr_data(wr_data),
    .st_we(st_we), .st_sel(st_sel), .st_data(st_data),
    .win_ptr(win_ptr), .save_avail(save_avail), .restore_avail(restore_avail),
    .foreign_wins(foreign_wins), .clean_wins(clean_wins)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [XLEN-1:0] mg [7];
  logic [XLEN-1:0] mw [NPHYS];
  int cur_ptr = 0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Physical index per R4
  function automatic int pidx(input int p, input int n);
    int w;
    w = (p + NWIN - n / 16) % NWIN;
    return 16 * w + (n % 16);
  endfunction

  function automatic logic [XLEN-1:0] mget(input int p, input int n);
    if (n == 0) return '0;
    if (n < 8) return mg[n-1];
    return mw[pidx(p, n)];
  endfunction

  function automatic logic [XLEN-1:0] mread(input int p, input int n, input logic m32);
    logic [XLEN-1:0] v;
    v = mget(p, n);
    return m32 ? {32'b0, v[31:0]} : v;
  endfunction

  task automatic do_write(input int n, input logic [XLEN-1:0] d, input logic m32);
    logic [XLEN-1:0] st;
    st = m32 ? {{32{d[31]}}, d[31:0]} : d;
    @(negedge clk);
    wr_valid = 1'b1; wr_num = 5'(n); wr_data = d; w32 = m32;
    ra_num = 5'(n); rb_pair = 1'b0;
    #1;
    // R6 bypass, R2 for name 0
    chk(n == 0 ? "R2 zero bypass" : "R6 bypass", ra_data,
        n == 0 ? '0 : (m32 ? {32'b0, st[31:0]} : st));
    @(negedge clk);
    wr_valid = 1'b0; w32 = 1'b0;
    if (n >= 8) mw[pidx(cur_ptr, n)] = st;
    else if (n > 0) mg[n-1] = st;
  endtask

  task automatic set_state(input int sel, input int v);
    @(negedge clk);
    st_we = 1'b1; st_sel = 3'(sel); st_data = 5'(v);
    @(negedge clk);
    st_we = 1'b0;
    if (sel == 0) cur_ptr = v;
  endtask

  task automatic read_all(input string req);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      ra_num = 5'(n); rb_num = 5'(31 - n); rb_pair = 1'b0;
      #1;
      chk(req, ra_data, mread(cur_ptr, n, w32));
      chk(req, rb_data, mread(cur_ptr, 31 - n, w32));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 7; i++) mg[i] = '0;
    for (int i = 0; i < NPHYS; i++) mw[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and zeroed registers
    chk("R1 win_ptr", 64'(win_ptr), 64'd0);
    chk("R1 save_avail", 64'(save_avail), 64'd6);
    chk("R1 restore_avail", 64'(restore_avail), 64'd0);
    chk("R1 foreign_wins", 64'(foreign_wins), 64'd0);
    chk("R1 clean_wins", 64'(clean_wins), 64'd7);
    read_all("R1 reset contents");

    // R3/R4/R2/R6 sweep over every pointer and name
    for (int p = 0; p < NWIN; p++) begin
      set_state(0, p);
      chk("R9 pointer load", 64'(win_ptr), 64'(p));
      for (int n = 0; n < 32; n++)
        do_write(n, {8'hA5, 8'(p), 8'(n), 8'h3C, 32'(p * 1000 + n * 7 + 1)}, 1'b0);
      read_all("R4 mapping");
    end

    // R3 globals unaffected by pointer; R5 neighbour overlap
    for (int p = 0; p < NWIN; p++) begin
      logic [XLEN-1:0] hi [8];
      set_state(0, p);
      for (int n = 24; n < 32; n++) begin
        @(negedge clk); ra_num = 5'(n); #1; hi[n-24] = ra_data;
      end
      for (int n = 1; n < 8; n++) begin
        @(negedge clk); ra_num = 5'(n); #1; chk("R3 global", ra_data, mg[n-1]);
      end
      set_state(0, (p + NWIN - 1) % NWIN);
      for (int n = 8; n < 16; n++) begin
        @(negedge clk); ra_num = 5'(n); #1; chk("R5 overlap", ra_data, hi[n-8]);
      end
    end

    // R7 32-bit access
    set_state(0, 3);
    do_write(9, 64'hDEAD_BEEF_8000_0001, 1'b1);
    @(negedge clk); ra_num = 5'd9; w32 = 1'b0; #1;
    chk("R7 sign extend", ra_data, 64'hFFFF_FFFF_8000_0001);
    w32 = 1'b1; #1;
    chk("R7 low word read", ra_data, 64'h0000_0000_8000_0001);
    do_write(10, 64'h1234_5678_7FFF_FFFF, 1'b1);
    @(negedge clk); ra_num = 5'd10; w32 = 1'b0; #1;
    chk("R7 positive extend", ra_data, 64'h0000_0000_7FFF_FFFF);
    @(negedge clk); w32 = 1'b1; ra_num = 5'd12; #1;
    chk("R7 32-bit read", ra_data, mread(cur_ptr, 12, 1'b1));
    w32 = 1'b0;

    // R8 pair reads
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      ra_num = 5'(n); rb_num = 5'(n ^ 5'h15); rb_pair = 1'b1; #1;
      chk("R8 pair", rb_data, mread(cur_ptr, (n + 1) % 32, 1'b0));
    end
    rb_pair = 1'b0;

    // R10 ready high, idle write ignored
    @(negedge clk);
    chk("R10 ready", 64'(wr_ready), 64'd1);
    wr_valid = 1'b0; wr_num = 5'd11; wr_data = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk); ra_num = 5'd11; #1;
    chk("R10 no write without valid", ra_data, mread(cur_ptr, 11, 1'b0));

    // R2 write to name 0 discarded
    do_write(0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    @(negedge clk); ra_num = 5'd0; rb_num = 5'd0; #1;
    chk("R2 zero after write", ra_data, '0);
    chk("R2 zero port B", rb_data, '0);

    // R9 counter selects and ignored codes
    set_state(1, 4);  chk("R9 save_avail", 64'(save_avail), 64'd4);
    set_state(2, 2);  chk("R9 restore_avail", 64'(restore_avail), 64'd2);
    set_state(3, 1);  chk("R9 foreign_wins", 64'(foreign_wins), 64'd1);
    set_state(4, 5);  chk("R9 clean_wins", 64'(clean_wins), 64'd5);
    for (int s = 5; s < 8; s++) begin
      set_state(s, 31);
      chk("R9 ignored ptr", 64'(win_ptr), 64'd3);
      chk("R9 ignored save", 64'(save_avail), 64'd4);
      chk("R9 ignored restore", 64'(restore_avail), 64'd2);
      chk("R9 ignored foreign", 64'(foreign_wins), 64'd1);
      chk("R9 ignored clean", 64'(clean_wins), 64'd5);
    end

    // R11 pointer beyond window count
    set_state(0, 9);
    chk("R11 ptr value", 64'(win_ptr), 64'd9);
    read_all("R11 pointer modulo");
    do_write(20, 64'h0BAD_CAFE_0000_0011, 1'b0);
    set_state(0, 1);
    @(negedge clk); ra_num = 5'd20; #1;
    chk("R11 alias write", ra_data, 64'h0BAD_CAFE_0000_0011);

    finish_run();
  end
endmodule